// File: doc/BRIEF.md
# Nested Exception Priority Controller

This block keeps the pending and active state of a set of prioritised exceptions. It decides when the best pending exception may interrupt the code that is running now. Each source has a request line, and a per-source sense bit selects edge or level behaviour. Every programmable source has an 8-bit priority register, written through a simple write port. The block also has a base priority mask input.

The controller raises a take request together with the number of the winning exception. The core answers with an entry handshake, which moves the exception from pending to active. When the handler finishes, the core sends a completion handshake. The current execution priority is always available as an output. It is the most urgent of the active exceptions and the base mask. Because it is recomputed every cycle, lowering the priority of a running handler lets the execution priority drop back to the next active level.

A lower value means higher urgency. Exception numbers 0 and 1 are fixed, non-programmable system exceptions, and they sit above every programmable level. Priorities are reported as 10-bit two's complement levels. Programmable levels are 0..255, the idle level is 256, source 0 is -2 and source 1 is -1.

Top module: `exc_prio_ctrl`

## Requirements
- R1: After reset, all pending and active bits are 0, take_o and err_o are 0, exec_prio_o is 256 and every programmable priority register holds 0.
- R2: A source whose sense bit is 0 (edge) becomes pending on the clock after a rising edge of its request. Holding the request high does not make it pending again.
- R3: A source whose sense bit is 1 (level) becomes pending while its request is high and it is not active. The pending bit stays set after the request drops, until entry. When the source becomes inactive with the request still high, it becomes pending again.
- R4: take_o is 1 only when the winning pending level is strictly lower in value than exec_prio_o. A pending source at a level equal to exec_prio_o stays pending and is not taken.
- R5: The winner is the pending source with the lowest level value. Among equal levels, the lowest exception number wins.
- R6: With no active exception, exec_prio_o equals base_mask_i when base_mask_i is nonzero, and 256 when base_mask_i is 0.
- R7: With active exceptions, exec_prio_o is the lowest value among the active levels and the mask level from R6.
- R8: A write that changes the priority of an active source changes exec_prio_o on the next cycle. Raising the value lets the execution priority fall back to the remaining active levels.
- R9: An entry handshake for exception n clears pend_o[n] and sets act_o[n] on the next clock.
- R10: A completion for exception n clears act_o[n]. A completion for an exception that is not active makes err_o 1 for exactly the next cycle.
- R11: Sources 0 and 1 have fixed levels -2 and -1. Writes to their priority index are ignored, and the base mask does not hold them back.
- R12: A priority write to a source with index 2 or above takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_EXC | Per-source request lines |
| irq_level_i | input | NUM_EXC | Per-source sense: 1 = level, 0 = edge |
| base_mask_i | input | 8 | Base priority mask, 0 = no mask |
| wr_en_i | input | 1 | Priority write strobe |
| wr_idx_i | input | IDX_W | Source index for the write |
| wr_prio_i | input | 8 | Priority value to write |
| entry_i | input | 1 | Core has entered an exception |
| entry_num_i | input | IDX_W | Exception number entered |
| done_i | input | 1 | Core has completed an exception |
| done_num_i | input | IDX_W | Exception number completed |
| take_o | output | 1 | A pending exception may preempt |
| take_num_o | output | IDX_W | Winning exception number |
| exec_prio_o | output | 10 | Current execution priority level (two's complement) |
| pend_o | output | NUM_EXC | Pending bits |
| act_o | output | NUM_EXC | Active bits |
| err_o | output | 1 | Completion for an exception that was not active |

## Verification
On every cycle the assertions check four things. A take request always names a pending source and always beats the execution priority strictly. An entry always leaves its exception active. A bad completion always raises the error flag for one cycle. The idle level is 256 whenever nothing is active and no mask is set. Some behaviour needs whole sequences, and only the bench scenarios can show it. These include tie-break order and equal-priority blocking under a mask. They also include the drop in execution priority after an active handler is reprioritised, the latched and re-pending behaviour of level sources, and fixed sources ignoring writes.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int PRIO_W = 8;
  localparam int LVL_W  = 10;
  typedef logic signed [LVL_W-1:0] eprio_t;
  localparam eprio_t IDLE_LVL = eprio_t'(256);

  // programmable register value -> signed level
  function automatic eprio_t prog_level(input logic [PRIO_W-1:0] p);
    return eprio_t'({2'b00, p});
  endfunction

  // fixed system exception i of nf -> negative level (-nf .. -1)
  function automatic eprio_t fixed_level(input int i, input int nf);
    return eprio_t'(i - nf);
  endfunction

  // base mask register -> level, zero means no masking
  function automatic eprio_t mask_level(input logic [PRIO_W-1:0] m);
    return (m == '0) ? IDLE_LVL : prog_level(m);
  endfunction

  function automatic eprio_t lvl_min(input eprio_t a, input eprio_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/exc_prio_regs.sv
module exc_prio_regs
  import exc_pkg::*;
#(
  parameter int NUM_EXC   = 16,
  parameter int NUM_FIXED = 2,
  localparam int IDX_W    = $clog2(NUM_EXC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PRIO_W-1:0] wr_prio,
  output eprio_t            lvl [NUM_EXC]
);
  for (genvar i = 0; i < NUM_EXC; i++) begin : g_src
    if (i < NUM_FIXED) begin : g_fixed
      assign lvl[i] = fixed_level(i, NUM_FIXED);
    end else begin : g_prog
      logic [PRIO_W-1:0] prio_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                               prio_q <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))    prio_q <= wr_prio;
      end
      assign lvl[i] = prog_level(prio_q);
    end
  end
endmodule

// File: rtl/exc_src_cell.sv
module exc_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic level,
  input  logic entry_hit,
  input  logic done_hit,
  output logic pend,
  output logic act
);
  logic req_q;
  logic edge_set;
  logic lvl_set;

  assign edge_set = !level && req && !req_q;
  assign lvl_set  = level && req && !act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      pend  <= 1'b0;
      act   <= 1'b0;
    end else begin
      req_q <= req;
      pend  <= (pend & ~entry_hit) | edge_set | (lvl_set & ~entry_hit);
      act   <= (act | entry_hit) & ~done_hit;
    end
  end
endmodule

// File: rtl/exc_min_sel.sv
module exc_min_sel
  import exc_pkg::*;
#(
  parameter int NUM_EXC = 16,
  localparam int IDX_W  = $clog2(NUM_EXC)
) (
  input  logic [NUM_EXC-1:0] valid,
  input  eprio_t             lvl [NUM_EXC],
  output logic               any,
  output logic [IDX_W-1:0]   best_idx,
  output eprio_t             best_lvl
);
  always_comb begin
    any      = 1'b0;
    best_idx = '0;
    best_lvl = IDLE_LVL;
    for (int i = 0; i < NUM_EXC; i++) begin
      // strict compare keeps the lowest number on ties
      if (valid[i] && (!any || lvl[i] < best_lvl)) begin
        any      = 1'b1;
        best_idx = IDX_W'(i);
        best_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/exc_prio_ctrl.sv
module exc_prio_ctrl
  import exc_pkg::*;
#(
  parameter int NUM_EXC   = 16,
  parameter int NUM_FIXED = 2,
  localparam int IDX_W    = $clog2(NUM_EXC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXC-1:0] irq_req_i,
  input  logic [NUM_EXC-1:0] irq_level_i,
  input  logic [7:0]         base_mask_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [7:0]         wr_prio_i,
  input  logic               entry_i,
  input  logic [IDX_W-1:0]   entry_num_i,
  input  logic               done_i,
  input  logic [IDX_W-1:0]   done_num_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   take_num_o,
  output logic [9:0]         exec_prio_o,
  output logic [NUM_EXC-1:0] pend_o,
  output logic [NUM_EXC-1:0] act_o,
  output logic               err_o
);
  eprio_t             lvl [NUM_EXC];
  logic [NUM_EXC-1:0] entry_hit;
  logic [NUM_EXC-1:0] done_hit;
  logic               pend_any;
  logic               act_any;
  logic [IDX_W-1:0]   act_idx;
  eprio_t             win_lvl;
  eprio_t             act_lvl;
  eprio_t             exec_lvl;
  logic               done_ok;
  logic               err_q;

  exc_prio_regs #(.NUM_EXC(NUM_EXC), .NUM_FIXED(NUM_FIXED)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_idx(wr_idx_i),
    .wr_prio(wr_prio_i), .lvl(lvl)
  );

  for (genvar i = 0; i < NUM_EXC; i++) begin : g_cell
    assign entry_hit[i] = entry_i && entry_num_i == IDX_W'(i);
    assign done_hit[i]  = done_i && done_num_i == IDX_W'(i);
    exc_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .req(irq_req_i[i]), .level(irq_level_i[i]),
      .entry_hit(entry_hit[i]), .done_hit(done_hit[i]),
      .pend(pend_o[i]), .act(act_o[i])
    );
  end

  exc_min_sel #(.NUM_EXC(NUM_EXC)) u_pend_sel (
    .valid(pend_o), .lvl(lvl), .any(pend_any), .best_idx(take_num_o),
    .best_lvl(win_lvl)
  );

  exc_min_sel #(.NUM_EXC(NUM_EXC)) u_act_sel (
    .valid(act_o), .lvl(lvl), .any(act_any), .best_idx(act_idx),
    .best_lvl(act_lvl)
  );

  assign exec_lvl    = lvl_min(act_any ? act_lvl : IDLE_LVL, mask_level(base_mask_i));
  assign exec_prio_o = exec_lvl;
  assign take_o      = pend_any && (win_lvl < exec_lvl);

  assign done_ok = |(done_hit & act_o);
  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= done_i && !done_ok;
  end
  assign err_o = err_q;

  logic unused_ok;
  assign unused_ok = ^act_idx;
endmodule

// File: rtl/exc_prio_chk.sv
module exc_prio_chk
  import exc_pkg::*;
#(
  parameter int NUM_EXC = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               take_o,
  input logic [IDX_W-1:0]   take_num_o,
  input eprio_t             win_lvl,
  input eprio_t             exec_lvl,
  input logic [NUM_EXC-1:0] pend_o,
  input logic [NUM_EXC-1:0] act_o,
  input logic [7:0]         base_mask_i,
  input logic               entry_i,
  input logic [IDX_W-1:0]   entry_num_i,
  input logic               done_i,
  input logic [IDX_W-1:0]   done_num_i,
  input logic               err_o
);
  a_r4_strict_beat: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (win_lvl < exec_lvl));

  a_r5_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> pend_o[take_num_o]);

  a_r9_entry_active: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_i && !(done_i && done_num_i == entry_num_i)) |=> act_o[$past(entry_num_i)]);

  a_r10_bad_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !act_o[done_num_i]) |=> err_o);

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> !err_o);

  a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o == '0 && base_mask_i == 8'd0) |-> (exec_lvl == IDLE_LVL));
endmodule

bind exc_prio_ctrl exc_prio_chk #(.NUM_EXC(NUM_EXC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_o(take_o), .take_num_o(take_num_o),
  .win_lvl(win_lvl), .exec_lvl(exec_lvl), .pend_o(pend_o), .act_o(act_o),
  .base_mask_i(base_mask_i), .entry_i(entry_i), .entry_num_i(entry_num_i),
  .done_i(done_i), .done_num_i(done_num_i), .err_o(err_o)
);

// File: tb/sim_exc_prio_ctrl.sv
module sim_exc_prio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, irq_level = '0;
  logic [7:0] base_mask = '0;
  logic wr_en = 1'b0, entry = 1'b0, done = 1'b0;
  logic [W-1:0] wr_idx = '0, entry_num = '0, done_num = '0;
  logic [7:0] wr_prio = '0;
  logic take;
  logic [W-1:0] take_num;
  logic [9:0] exec_prio;
  logic [N-1:0] pend, act;
  logic err;
  int total = 0, bad = 0;
  logic finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_prio_ctrl #(.NUM_EXC(N), .NUM_FIXED(2)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .irq_level_i(irq_level),
    .base_mask_i(base_mask), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_prio_i(wr_prio),
    .entry_i(entry), .entry_num_i(entry_num), .done_i(done), .done_num_i(done_num),
    .take_o(take), .take_num_o(take_num), .exec_prio_o(exec_prio),
    .pend_o(pend), .act_o(act), .err_o(err)
  );

  // rows: src_a, prio_a, src_b, prio_b, expected winner
  localparam int ROWS = 6;
  localparam int VEC [ROWS][5] = '{
    '{3, 10, 5, 20, 3},
    '{3, 30, 5, 20, 5},
    '{4,  7, 9,  7, 4},
    '{9,  7, 4,  7, 4},
    '{0,  0, 6,  0, 0},
    '{1,  0, 0,  0, 0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input int p);
    wr_en = 1'b1; wr_idx = W'(idx); wr_prio = 8'(p);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse2(input int a, input int b);
    irq_req[a] = 1'b1; irq_req[b] = 1'b1;
    tick();
    irq_req[a] = 1'b0; irq_req[b] = 1'b0;
  endtask

  task automatic enter(input int idx);
    entry = 1'b1; entry_num = W'(idx);
    tick();
    entry = 1'b0;
  endtask

  task automatic finish(input int idx);
    done = 1'b1; done_num = W'(idx);
    tick();
    done = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 pend", 32'(pend), 0);
    check("R1 act", 32'(act), 0);
    check("R1 take", 32'(take), 0);
    check("R1 err", 32'(err), 0);
    check("R1 exec", 32'(exec_prio), 256);
    // R1: prio regs reset to 0 -> a source pulsed enters at level 0
    pulse2(7, 7);
    check("R1 take at idle", 32'(take), 1);
    enter(7);
    check("R1 reg zero level", 32'(exec_prio), 0);
    finish(7);

    // table of arbitration vectors (R5, R11, R9)
    for (int r = 0; r < ROWS; r++) begin
      int a, b, w, o;
      a = VEC[r][0]; b = VEC[r][2]; w = VEC[r][4];
      o = (w == a) ? b : a;
      wr(a, VEC[r][1]);
      wr(b, VEC[r][3]);
      pulse2(a, b);
      check("R5 take", 32'(take), 1);
      check("R5 winner", 32'(take_num), 32'(w));
      enter(w);
      check("R9 active", 32'(act[w]), 1);
      check("R9 pend clr", 32'(pend[w]), 0);
      finish(w);
      check("R10 act clr", 32'(act[w]), 0);
      check("R5 next", 32'(take_num), 32'(o));
      enter(o);
      finish(o);
      check("R10 idle", 32'(act), 0);
    end

    // R6/R4: mask equal to priority blocks
    base_mask = 8'd50;
    wr(7, 50);
    tick();
    check("R6 exec mask", 32'(exec_prio), 50);
    pulse2(7, 7);
    check("R4 equal not taken", 32'(take), 0);
    check("R4 still pending", 32'(pend[7]), 1);
    base_mask = 8'd49;
    #1 check("R4 blocked by mask", 32'(take), 0);
    base_mask = 8'd0;
    #1 check("R6 unmasked take", 32'(take), 1);
    tick();
    enter(7);
    check("R7 exec active", 32'(exec_prio), 50);
    // equal priority does not preempt
    wr(8, 50);
    pulse2(8, 8);
    check("R4 equal active no take", 32'(take), 0);
    wr(8, 40);
    check("R12 write raises", 32'(take), 1);
    enter(8);
    check("R7 nested exec", 32'(exec_prio), 40);
    wr(8, 200);
    check("R8 exec drops", 32'(exec_prio), 50);
    base_mask = 8'd30;
    #1 check("R7 mask below active", 32'(exec_prio), 30);
    base_mask = 8'd0;
    finish(8);
    finish(7);
    check("R6 back idle", 32'(exec_prio), 256);

    // R10: bad completion
    finish(3);
    check("R10 err pulse", 32'(err), 1);
    tick();
    check("R10 err clears", 32'(err), 0);

    // R3 level source
    irq_level[10] = 1'b1;
    wr(10, 5);
    irq_req[10] = 1'b1;
    tick();
    check("R3 level pend", 32'(pend[10]), 1);
    irq_req[10] = 1'b0;
    tick(); tick();
    check("R3 latched", 32'(pend[10]), 1);
    irq_req[10] = 1'b1;
    enter(10);
    tick();
    check("R3 no pend while active", 32'(pend[10]), 0);
    finish(10);
    tick();
    check("R3 re-pend", 32'(pend[10]), 1);
    irq_req[10] = 1'b0;
    enter(10);
    finish(10);
    tick();
    check("R3 cleared", 32'(pend[10]), 0);
    irq_level[10] = 1'b0;

    // R2 edge source held high
    irq_req[11] = 1'b1;
    tick();
    check("R2 edge pend", 32'(pend[11]), 1);
    enter(11);
    tick(); tick();
    finish(11);
    tick();
    check("R2 no repend", 32'(pend[11]), 0);
    irq_req[11] = 1'b0;
    tick();

    // R11 fixed sources ignore writes and mask
    wr(0, 200);
    wr(1, 200);
    base_mask = 8'd1;
    pulse2(0, 1);
    check("R11 take under mask", 32'(take), 1);
    check("R11 order", 32'(take_num), 0);
    enter(0);
    check("R11 level0", 32'(exec_prio), 32'h3FE);
    enter(1);
    finish(0);
    check("R11 level1", 32'(exec_prio), 32'h3FF);
    finish(1);
    check("R6 mask idle", 32'(exec_prio), 1);
    base_mask = 8'd0;

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule